// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block produces the frame synchronisation signal of a time-division multiplexed serial port. The clock `clk` is the bit clock: one rising edge per serial bit. A bit counter gives the position of the current bit inside the frame, and downstream serialisers use this position to pick their timeslots. A strobe marks the first bit of every frame.

A small set of plain configuration pins selects the waveform on the single sync line. The choices are a word-select style for stereo audio, a one-bit short pulse, or an eight-bit long pulse. Each can be aligned with the first data bit or placed one bit earlier. A wideband option adds a second pulse at mid-frame. The frame length in bits is also a pin. In master mode the block drives the sync line and asks for the bit clock to be driven as well. In slave mode it follows an external sync and realigns its counter to that signal.

The configuration pins are sampled only on the last bit of each frame, so a change never cuts a pulse short. The block has no data stream, so it has no valid/ready handshake. All pins are plain control or status lines.

Top module: `tdm_fsync_gen`

## Requirements
- R1: While `rst_n` is low, `bit_pos`, `sync_out`, `sync_oe`, `bclk_drive` and `frame_start` are all 0. On the first cycle after release the configuration is loaded, `bit_pos` is 0 and `frame_start` is 0. On the following cycle the first frame starts with `bit_pos` 0 and `frame_start` 1.
- R2: Without a resync, `bit_pos` advances by one per clock from 0 to L-1 and then wraps to 0, where L is the loaded frame length. `frame_start` is 1 exactly on cycles where `bit_pos` is 0, apart from the load cycle of R1.
- R3: With `cfg_style`=2'b10 (short), `sync_out` is high for one bit at position 0. With `cfg_wide`=1 it is also high at position L/2.
- R4: With `cfg_style`=2'b11 (long), `sync_out` is high for positions 0 to 7. With `cfg_wide`=1 it is also high for positions L/2 to L/2+7.
- R5: With `cfg_early`=1, the short and long waveforms move one bit earlier, so a pulse that would start at position 0 starts at position L-1 of the frame before.
- R6: With `cfg_style`=2'b01 and `cfg_wide`=0 (word select), `sync_out` is high for positions L/2-1 to L-2 and low elsewhere, whatever the value of `cfg_early`.
- R7: With `cfg_style`=2'b00, or with `cfg_style`=2'b01 and `cfg_wide`=1, `sync_out` stays 0.
- R8: `sync_oe` and `bclk_drive` follow the loaded master bit (`cfg_master`=1 means master). In slave mode `sync_out` is 0.
- R9: Configuration inputs are sampled only on the cycle where `bit_pos` is L-1 (or the load cycle of R1). A change in mid-frame does not affect the outputs until the next frame begins.
- R10: In slave mode with the short or long style, a rising edge on `sync_in` marks the current bit as position 0 when `cfg_early`=0, and as position L-1 when `cfg_early`=1. `bit_pos` shows that position in the same cycle.
- R11: In slave mode with the word-select style, a falling edge on `sync_in` marks the current bit as position L-1.
- R12: In slave mode with `cfg_wide`=1, a rising edge that comes while the counter is already at the mid-frame pulse position (L/2, or L/2-1 when early) is taken as the second pulse and does not realign the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = drive sync and bit clock, 0 = follow external sync |
| cfg_wide | input | 1 | Wideband: second pulse at mid-frame |
| cfg_early | input | 1 | Place the sync one bit before the first data bit |
| cfg_style | input | 2 | 00 none, 01 word select, 10 short, 11 long |
| cfg_len | input | LEN_W | Frame length in bits (even, at least 16) |
| sync_in | input | 1 | External sync in slave mode |
| sync_out | output | 1 | Generated sync in master mode |
| sync_oe | output | 1 | Output enable for the sync pad |
| bclk_drive | output | 1 | Request to drive the bit clock pad |
| frame_start | output | 1 | High on bit 0 of each frame |
| bit_pos | output | LEN_W | Current bit position in the frame |

## Verification
The assertions assume that `cfg_len` is even and at least 16, so that the long pulse and the mid-frame position fit inside one frame and a resync never leaves the counter out of range. They also assume that `sync_in` carries edges only at sensible points in slave mode. The stimulus uses only the lengths 16, 20 and 32, holds `sync_in` low in master mode, and gives single pulses or one word-select falling edge in slave mode. Configuration changes are made at arbitrary bits and are checked against the frame boundary.

// File: rtl/tdm_fsync_pkg.sv
package tdm_fsync_pkg;
  typedef enum logic [1:0] {
    STYLE_NONE  = 2'b00,
    STYLE_WS    = 2'b01,
    STYLE_SHORT = 2'b10,
    STYLE_LONG  = 2'b11
  } style_e;

  typedef struct packed {
    logic   master;
    logic   wide;
    logic   early;
    style_e style;
  } ctl_t;
endpackage

// File: rtl/tdm_cfg_shadow.sv
module tdm_cfg_shadow
  import tdm_fsync_pkg::*;
#(
  parameter int LEN_W   = 10,
  parameter int DEF_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  ctl_t             ctl_in,
  input  logic [LEN_W-1:0] len_in,
  output ctl_t             ctl_q,
  output logic [LEN_W-1:0] len_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{master: 1'b0, wide: 1'b0, early: 1'b0, style: STYLE_NONE};
      len_q <= LEN_W'(DEF_LEN);
    end else if (load) begin
      ctl_q <= ctl_in;
      len_q <= len_in;
    end
  end

  // Settings only move at a frame boundary
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(ctl_q) && $stable(len_q)));
endmodule

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter
  import tdm_fsync_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl,
  input  logic [LEN_W-1:0] len,
  input  logic             sync_in,
  output logic [LEN_W-1:0] cur_pos,
  output logic             boundary,
  output logic             valid,
  output logic             resync
);
  logic             pend_q, sync_q;
  logic [LEN_W-1:0] cnt_q, last, half, mid_pos;
  logic             lead, rise, fall, edge_ok;

  assign last    = len - LEN_W'(1);
  assign half    = len >> 1;
  assign lead    = ctl.early || (ctl.style == STYLE_WS);
  assign mid_pos = lead ? (half - LEN_W'(1)) : half;
  assign rise    = sync_in && !sync_q;
  assign fall    = !sync_in && sync_q;

  always_comb begin
    unique case (ctl.style)
      STYLE_SHORT, STYLE_LONG: edge_ok = rise;
      STYLE_WS:                edge_ok = fall && !ctl.wide;
      default:                 edge_ok = 1'b0;
    endcase
  end

  assign resync   = !pend_q && !ctl.master && edge_ok && !(ctl.wide && (cnt_q == mid_pos));
  assign cur_pos  = resync ? (lead ? last : '0) : cnt_q;
  assign boundary = pend_q || (cur_pos >= last);
  assign valid    = !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= 1'b0;
      sync_q <= sync_in;
      cnt_q  <= boundary ? '0 : cur_pos + LEN_W'(1);
    end
  end

  assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len);
  assert_resync_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && !lead) |=> (cnt_q == LEN_W'(1)));
  assert_resync_lead_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && lead) |=> (cnt_q == '0));
endmodule

// File: rtl/tdm_sync_shaper.sv
module tdm_sync_shaper
  import tdm_fsync_pkg::*;
#(
  parameter int LEN_W     = 10,
  parameter int LONG_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             load,
  input  logic [LEN_W-1:0] pos,
  input  logic [LEN_W-1:0] len,
  input  ctl_t             ctl,
  output logic             sync_out
);
  localparam int EW = LEN_W + 1;

  logic [EW-1:0] len_e, pos_e, half_e, nxt_e, ref_e, long_e;
  logic          short_hit, long_hit, ws_hit, hit;

  assign len_e  = {1'b0, len};
  assign pos_e  = {1'b0, pos};
  assign half_e = len_e >> 1;
  assign long_e = EW'(LONG_BITS);
  assign nxt_e  = ((pos_e + EW'(1)) >= len_e) ? '0 : (pos_e + EW'(1));
  assign ref_e  = (ctl.early || (ctl.style == STYLE_WS)) ? nxt_e : pos_e;

  assign short_hit = (ref_e == '0) || (ctl.wide && (ref_e == half_e));
  assign long_hit  = (ref_e < long_e) ||
                     (ctl.wide && (ref_e >= half_e) && (ref_e < (half_e + long_e)));
  assign ws_hit    = !ctl.wide && (ref_e >= half_e);

  always_comb begin
    unique case (ctl.style)
      STYLE_WS:    hit = ws_hit;
      STYLE_SHORT: hit = short_hit;
      STYLE_LONG:  hit = long_hit;
      default:     hit = 1'b0;
    endcase
  end

  assign sync_out = active && hit;

  assert_short_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl.style == STYLE_SHORT) && sync_out && !load) |=> !sync_out);
  assert_no_style_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl.style == STYLE_NONE) || ((ctl.style == STYLE_WS) && ctl.wide)) |-> !sync_out);
endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
  import tdm_fsync_pkg::*;
#(
  parameter int LEN_W     = 10,
  parameter int DEF_LEN   = 256,
  parameter int LONG_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_wide,
  input  logic             cfg_early,
  input  logic [1:0]       cfg_style,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             sync_in,
  output logic             sync_out,
  output logic             sync_oe,
  output logic             bclk_drive,
  output logic             frame_start,
  output logic [LEN_W-1:0] bit_pos
);
  ctl_t             ctl_in, act;
  logic [LEN_W-1:0] act_len, cur_pos;
  logic             boundary, valid, resync;

  assign ctl_in = '{master: cfg_master, wide: cfg_wide, early: cfg_early,
                    style: style_e'(cfg_style)};

  tdm_cfg_shadow #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(boundary), .ctl_in(ctl_in),
    .len_in(cfg_len), .ctl_q(act), .len_q(act_len)
  );

  tdm_bit_counter #(.LEN_W(LEN_W)) u_count (
    .clk(clk), .rst_n(rst_n), .ctl(act), .len(act_len), .sync_in(sync_in),
    .cur_pos(cur_pos), .boundary(boundary), .valid(valid), .resync(resync)
  );

  tdm_sync_shaper #(.LEN_W(LEN_W), .LONG_BITS(LONG_BITS)) u_shape (
    .clk(clk), .rst_n(rst_n), .active(valid && act.master), .load(boundary),
    .pos(cur_pos), .len(act_len), .ctl(act), .sync_out(sync_out)
  );

  assign bit_pos     = cur_pos;
  assign frame_start = valid && (cur_pos == '0);
  assign sync_oe     = act.master;
  assign bclk_drive  = act.master;

  // A resync never happens while this block drives the line
  assert_slave_resync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> (!sync_oe && !sync_out));
endmodule

// File: tb/tdm_fsync_gen_tb_top.sv
module tdm_fsync_gen_tb_top;
  localparam int LEN_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_wide = 1'b0, cfg_early = 1'b0;
  logic [1:0] cfg_style = 2'b10;
  logic [LEN_W-1:0] cfg_len = 16;
  logic sync_in = 1'b0;
  logic sync_out, sync_oe, bclk_drive, frame_start;
  logic [LEN_W-1:0] bit_pos;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tdm_fsync_gen #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
    .cfg_early(cfg_early), .cfg_style(cfg_style), .cfg_len(cfg_len),
    .sync_in(sync_in), .sync_out(sync_out), .sync_oe(sync_oe),
    .bclk_drive(bclk_drive), .frame_start(frame_start), .bit_pos(bit_pos)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic bit exp_sync(int p, int st, bit wd, bit er, int L);
    int h = L / 2;
    int r = (er || st == 1) ? (p + 1) % L : p;
    case (st)
      1: return !wd && (r >= h);
      2: return (r == 0) || (wd && r == h);
      3: return (r < 8) || (wd && r >= h && r < h + 8);
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_cfg(bit m, int st, bit wd, bit er, int L);
    cfg_master = m; cfg_style = st[1:0]; cfg_wide = wd; cfg_early = er;
    cfg_len = L[LEN_W-1:0];
  endtask

  task automatic wait_frame();
    for (int k = 0; k < 400; k++) begin
      tick(); #1;
      if (frame_start) return;
    end
    check("R2 frame_start seen", 0, 1);
  endtask

  task automatic test_reset();
    set_cfg(1, 2, 0, 0, 16);
    repeat (3) tick();
    #1;
    check("R1 bit_pos", bit_pos, 0);
    check("R1 sync_out", sync_out, 0);
    check("R1 sync_oe", sync_oe, 0);
    check("R1 bclk_drive", bclk_drive, 0);
    check("R1 frame_start", frame_start, 0);
    tick(); rst_n = 1'b1; #1;
    check("R1 load cycle frame_start", frame_start, 0);
    check("R1 load cycle bit_pos", bit_pos, 0);
    tick(); #1;
    check("R1 first frame_start", frame_start, 1);
    check("R1 first sync_out", sync_out, 1);
    check("R1 sync_oe after load", sync_oe, 1);
  endtask

  task automatic run_master(input string req, int st, bit wd, bit er, int L, int frames);
    set_cfg(1, st, wd, er, L);
    wait_frame();
    for (int i = 0; i < frames * L; i++) begin
      check("R2 bit_pos", bit_pos, i % L);
      check("R2 frame_start", frame_start, (i % L) == 0);
      check({req, " sync_out"}, sync_out, exp_sync(i % L, st, wd, er, L));
      check("R8 sync_oe master", sync_oe, 1);
      check("R8 bclk_drive master", bclk_drive, 1);
      tick(); #1;
    end
  endtask

  task automatic test_deferred();
    set_cfg(1, 2, 0, 0, 16);
    wait_frame();
    for (int i = 0; i < 16 + 20; i++) begin
      if (i < 16) begin
        check("R9 old bit_pos", bit_pos, i);
        check("R9 old sync_out", sync_out, exp_sync(i, 2, 0, 0, 16));
      end else begin
        check("R9 new bit_pos", bit_pos, i - 16);
        check("R9 new sync_out", sync_out, exp_sync(i - 16, 3, 0, 0, 20));
      end
      tick();
      if (i == 4) set_cfg(1, 3, 0, 0, 20);
      #1;
    end
  endtask

  task automatic test_slave_rise(input string req, bit er);
    set_cfg(0, 2, 0, er, 16);
    wait_frame();
    check("R8 slave sync_oe", sync_oe, 0);
    check("R8 slave bclk_drive", bclk_drive, 0);
    repeat (5) tick();
    tick(); sync_in = 1'b1; #1;
    check({req, " resync bit_pos"}, bit_pos, er ? 15 : 0);
    check({req, " resync frame_start"}, frame_start, er ? 0 : 1);
    check("R8 slave sync_out", sync_out, 0);
    tick(); sync_in = 1'b0; #1;
    check({req, " after resync bit_pos"}, bit_pos, er ? 0 : 1);
    for (int i = 0; i < 10; i++) begin
      tick(); #1;
      check({req, " follow bit_pos"}, bit_pos, (er ? 1 : 2) + i);
    end
  endtask

  task automatic test_slave_wide();
    set_cfg(0, 2, 1, 0, 16);
    wait_frame();
    repeat (2) tick();
    tick(); sync_in = 1'b1; #1;
    check("R12 lock bit_pos", bit_pos, 0);
    tick(); sync_in = 1'b0; #1;
    for (int i = 1; i < 8; i++) begin
      check("R12 count to mid", bit_pos, i);
      tick(); #1;
    end
    sync_in = 1'b1; #1;
    check("R12 mid pulse keeps bit_pos", bit_pos, 8);
    tick(); sync_in = 1'b0; #1;
    check("R12 after mid pulse", bit_pos, 9);
  endtask

  task automatic test_slave_ws();
    set_cfg(0, 1, 0, 0, 16);
    wait_frame();
    tick(); sync_in = 1'b1; #1;
    check("R11 rise ignored", bit_pos, 1);
    repeat (2) tick();
    tick(); sync_in = 1'b0; #1;
    check("R11 fall bit_pos", bit_pos, 15);
    check("R11 fall frame_start", frame_start, 0);
    tick(); #1;
    check("R11 next bit_pos", bit_pos, 0);
    check("R11 next frame_start", frame_start, 1);
  endtask

  initial begin
    test_reset();
    run_master("R3 short narrow", 2, 0, 0, 16, 2);
    run_master("R3 short wide", 2, 1, 0, 16, 2);
    run_master("R5 short early", 2, 0, 1, 16, 2);
    run_master("R4 long narrow", 3, 0, 0, 20, 2);
    run_master("R4 long wide", 3, 1, 0, 32, 2);
    run_master("R5 long early wide", 3, 1, 1, 32, 2);
    run_master("R6 word select", 1, 0, 1, 16, 2);
    run_master("R6 word select plain", 1, 0, 0, 20, 1);
    run_master("R7 style none", 0, 0, 0, 16, 1);
    run_master("R7 word select wide", 1, 1, 0, 16, 1);
    test_deferred();
    test_slave_rise("R10 plain", 1'b0);
    test_slave_rise("R10 early", 1'b1);
    test_slave_wide();
    test_slave_ws();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule